// File: doc/BRIEF.md
# Dual-Instruction Word Fetch Sequencer

This block is the instruction fetch front end of a small accumulator machine. Every memory word is 40 bits wide and packs two 20-bit instructions. Each instruction is an 8-bit opcode in its upper bits and a 12-bit operand address in its lower bits. The sequencer reads a word over a request/valid read port and splits it into its two halves. The left half (bits 39:20) is handed to the execute stage first. The right half (bits 19:0) is parked in a buffer register, so the following fetch is served without any memory access.

The program counter addresses word pairs, not single instructions. It advances once per memory read and wraps from the last word, 999, back to 0. Each delivered instruction is announced by a one-cycle valid pulse. The opcode and operand outputs then hold until the execute stage reports completion. When the execute stage completes an instruction, it may also request a branch. The branch reloads the program counter, throws away any buffered right half and selects whether execution resumes at the left or the right half of the target word.

Top module: `pair_fetch_seq`

## Requirements
- R1: While reset is asserted, mem_req and insn_valid are 0. The first fetch after reset reads word address 0.
- R2: For a word read from memory, the half in bits 39:20 is delivered first. For either half, opcode is the upper 8 bits of the 20-bit half and operand is its lower 12 bits.
- R3: After a left half is delivered, the next fetch delivers the right half (bits 19:0) of the same word from the buffer. This fetch makes no memory read: mem_req stays 0.
- R4: The word address advances by one per memory read and wraps from 999 to 0.
- R5: Once mem_req is raised, it stays high and mem_addr stays unchanged until a cycle in which mem_rvalid is 1. The sequencer works for any number of wait cycles.
- R6: insn_valid is high for exactly one cycle per delivered instruction. opcode and operand hold their values between pulses. No further instruction is fetched until exec_done is seen.
- R7: br_req sampled together with exec_done loads br_target as the next word address and discards a buffered right half. With br_right = 0, the left half of the target word comes next and then its right half. With br_right = 1, only the right half of the target word is delivered, followed by the left half of the target + 1 word.
- R8: br_req sampled without exec_done has no effect on the instruction sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Read request to memory, held until data is valid |
| mem_addr | output | 12 | Word address of the read |
| mem_rdata | input | 40 | Read data, taken when mem_rvalid is 1 |
| mem_rvalid | input | 1 | Read data valid |
| insn_valid | output | 1 | One-cycle pulse: a new instruction is on opcode/operand |
| opcode | output | 8 | Opcode of the current instruction |
| operand | output | 12 | Operand address of the current instruction |
| exec_done | input | 1 | Execute stage has finished the current instruction |
| br_req | input | 1 | Branch request, taken only together with exec_done |
| br_target | input | 12 | Word address of the branch target |
| br_right | input | 1 | 1: resume at the right half of the target word |

## Verification
The critical coincidence is a branch that arrives while the buffer still holds an unused right half. In that cycle the buffer's own drain is pending and the branch must clear it. The bench provokes this by completing a left-half instruction with exec_done and br_req raised together. It then judges the next delivered instruction: it must be the target's left half, not the stale right half, and it must come with exactly one new memory read at the target address. A second coincidence is a right-half branch that also advances the address on the read. It is judged by requiring the word after the target to be read next.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    ST_PICK  = 2'd0,
    ST_READ  = 2'd1,
    ST_SPLIT = 2'd2,
    ST_EXEC  = 2'd3
  } fetch_st_t;
endpackage

// File: rtl/pf_pc.sv
module pf_pc #(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_WORDS - 1);

  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] cur);
    return (cur >= LAST) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    pc <= '0;
    else if (load) pc <= load_val;
    else if (step) pc <= pc_step(pc);
  end
endmodule

// File: rtl/pf_ibuf.sv
module pf_ibuf #(
  parameter int INSN_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill,
  input  logic [INSN_W-1:0] fill_val,
  input  logic              drain,
  input  logic              clear,
  output logic              valid,
  output logic [INSN_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      if (clear || drain) valid <= 1'b0;
      else if (fill)      valid <= 1'b1;
      if (fill) data <= fill_val;
    end
  end
endmodule

// File: rtl/pair_fetch_seq.sv
module pair_fetch_seq #(
  parameter int OPC_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 1000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic                          mem_req,
  output logic [ADDR_W-1:0]             mem_addr,
  input  logic [2*(OPC_W+ADDR_W)-1:0]   mem_rdata,
  input  logic                          mem_rvalid,
  output logic                          insn_valid,
  output logic [OPC_W-1:0]              opcode,
  output logic [ADDR_W-1:0]             operand,
  input  logic                          exec_done,
  input  logic                          br_req,
  input  logic [ADDR_W-1:0]             br_target,
  input  logic                          br_right
);
  import pf_pkg::*;

  localparam int INSN_W = OPC_W + ADDR_W;
  localparam int WORD_W = 2 * INSN_W;

  function automatic logic [INSN_W-1:0] left_half(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:INSN_W];
  endfunction

  function automatic logic [INSN_W-1:0] right_half(input logic [WORD_W-1:0] w);
    return w[INSN_W-1:0];
  endfunction

  function automatic logic [OPC_W-1:0] opc_of(input logic [INSN_W-1:0] i);
    return i[INSN_W-1:ADDR_W];
  endfunction

  function automatic logic [ADDR_W-1:0] adr_of(input logic [INSN_W-1:0] i);
    return i[ADDR_W-1:0];
  endfunction

  fetch_st_t         state;
  logic [WORD_W-1:0] mbr;
  logic [OPC_W-1:0]  ir;
  logic [ADDR_W-1:0] ar;
  logic [ADDR_W-1:0] mar;
  logic              iv;
  logic              start_right;
  logic [ADDR_W-1:0] pc;
  logic              buf_valid;
  logic [INSN_W-1:0] buf_data;
  logic [INSN_W-1:0] split_sel;

  // named events, also observed by the checker
  logic ev_buf_hit, ev_word_in, ev_accept, ev_branch, ev_fill;
  assign ev_buf_hit = (state == ST_PICK) && buf_valid;
  assign ev_word_in = (state == ST_READ) && mem_rvalid;
  assign ev_accept  = (state == ST_EXEC) && exec_done;
  assign ev_branch  = ev_accept && br_req;
  assign ev_fill    = (state == ST_SPLIT) && !start_right;
  assign split_sel  = start_right ? right_half(mbr) : left_half(mbr);

  pf_pc #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_pc (
    .clk(clk), .rst_n(rst_n), .step(ev_word_in), .load(ev_branch),
    .load_val(br_target), .pc(pc)
  );

  pf_ibuf #(.INSN_W(INSN_W)) u_ibuf (
    .clk(clk), .rst_n(rst_n), .fill(ev_fill), .fill_val(right_half(mbr)),
    .drain(ev_buf_hit), .clear(ev_branch), .valid(buf_valid), .data(buf_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_PICK;
      mbr         <= '0;
      ir          <= '0;
      ar          <= '0;
      mar         <= '0;
      iv          <= 1'b0;
      start_right <= 1'b0;
    end else begin
      iv <= 1'b0;
      case (state)
        ST_PICK: begin
          if (buf_valid) begin
            ir    <= opc_of(buf_data);
            ar    <= adr_of(buf_data);
            iv    <= 1'b1;
            state <= ST_EXEC;
          end else begin
            mar   <= pc;
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_rvalid) begin
            mbr   <= mem_rdata;
            state <= ST_SPLIT;
          end
        end
        ST_SPLIT: begin
          ir          <= opc_of(split_sel);
          ar          <= adr_of(split_sel);
          iv          <= 1'b1;
          start_right <= 1'b0;
          state       <= ST_EXEC;
        end
        default: begin
          if (exec_done) begin
            if (br_req) start_right <= br_right;
            state <= ST_PICK;
          end
        end
      endcase
    end
  end

  assign mem_req    = (state == ST_READ);
  assign mem_addr   = mar;
  assign insn_valid = iv;
  assign opcode     = ir;
  assign operand    = ar;
endmodule

// File: rtl/pf_checks.sv
module pf_checks #(
  parameter int OPC_W  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              insn_valid,
  input logic [OPC_W-1:0]  opcode,
  input logic [ADDR_W-1:0] operand,
  input logic              ev_buf_hit,
  input logic              ev_branch,
  input logic              buf_valid
);
  // R5: request held with a steady address until data arrives
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  // R6: valid is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> !insn_valid);

  // R6: outputs only move together with a valid pulse
  a_r6_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> $stable(opcode) && $stable(operand));

  // R3: buffered fetch delivers without a memory request
  a_r3_buffer_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buf_hit |=> insn_valid && !mem_req);

  // R7: a taken branch leaves no buffered instruction
  a_r7_branch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_branch |=> !buf_valid);
endmodule

bind pair_fetch_seq pf_checks #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .mem_addr(mem_addr), .insn_valid(insn_valid), .opcode(opcode),
  .operand(operand), .ev_buf_hit(ev_buf_hit), .ev_branch(ev_branch),
  .buf_valid(buf_valid)
);

// File: tb/pair_fetch_seq_test.sv
`timescale 1ns/1ps
module pair_fetch_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req;
  logic [11:0] mem_addr;
  logic [39:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic        insn_valid;
  logic [7:0]  opcode;
  logic [11:0] operand;
  logic        exec_done = 1'b0;
  logic        br_req = 1'b0;
  logic [11:0] br_target = '0;
  logic        br_right = 1'b0;

  int checks = 0;
  int errors = 0;
  int reads = 0;
  int last_addr = -1;
  int lat = 0;
  int wait_cnt = 0;

  always #5 clk = ~clk;

  pair_fetch_seq uut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .insn_valid(insn_valid),
    .opcode(opcode), .operand(operand), .exec_done(exec_done),
    .br_req(br_req), .br_target(br_target), .br_right(br_right)
  );

  // test pattern per word: left and right halves derived from the address
  function automatic logic [7:0]  l_op(input int a);  return 8'(a * 3 + 1);  endfunction
  function automatic logic [11:0] l_ad(input int a);  return 12'(a + 100);   endfunction
  function automatic logic [7:0]  r_op(input int a);  return 8'(a * 5 + 2);  endfunction
  function automatic logic [11:0] r_ad(input int a);  return 12'(a + 200);   endfunction

  // memory model: answers a request after lat wait cycles, one-cycle valid
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_rdata  = {l_op(int'(mem_addr)), l_ad(int'(mem_addr)),
                      r_op(int'(mem_addr)), r_ad(int'(mem_addr))};
        mem_rvalid = 1'b1;
        reads++;
        last_addr = int'(mem_addr);
        wait_cnt  = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic get_insn(input string tag, input logic [7:0] eop, input logic [11:0] ead);
    int n = 0;
    @(negedge clk);
    while (!insn_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check({tag, " insn_valid seen"}, longint'(insn_valid), 1);
    check({tag, " opcode"}, longint'(opcode), longint'(eop));
    check({tag, " operand"}, longint'(operand), longint'(ead));
  endtask

  task automatic finish_insn(input logic br, input int tgt, input logic right);
    exec_done = 1'b1;
    br_req    = br;
    br_target = 12'(tgt);
    br_right  = right;
    @(negedge clk);
    exec_done = 1'b0;
    br_req    = 1'b0;
    br_right  = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 mem_req in reset", longint'(mem_req), 0);
    check("R1 insn_valid in reset", longint'(insn_valid), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_seq();
    lat = 0;
    get_insn("R1 R2 left of word 0", l_op(0), l_ad(0));
    check("R1 first read address", last_addr, 0);
    check("R2 one read", reads, 1);
    finish_insn(1'b0, 0, 1'b0);
    get_insn("R3 right of word 0", r_op(0), r_ad(0));
    check("R3 no read for buffered half", reads, 1);
    finish_insn(1'b0, 0, 1'b0);
    get_insn("R4 left of word 1", l_op(1), l_ad(1));
    check("R4 address advanced", last_addr, 1);
    finish_insn(1'b0, 0, 1'b0);
    get_insn("R3 right of word 1", r_op(1), r_ad(1));
    check("R3 reads after word 1", reads, 2);
    finish_insn(1'b0, 0, 1'b0);
  endtask

  task automatic t_pulse();
    int r0;
    lat = 5;
    get_insn("R5 left of word 2 with waits", l_op(2), l_ad(2));
    check("R5 address after waits", last_addr, 2);
    r0 = reads;
    repeat (4) @(negedge clk);
    check("R6 pulse ended", longint'(insn_valid), 0);
    check("R6 opcode held", longint'(opcode), longint'(l_op(2)));
    check("R6 no fetch before done", longint'(mem_req), 0);
    check("R6 no read before done", reads, r0);
  endtask

  task automatic t_ignore_branch();
    lat = 2;
    br_req    = 1'b1;
    br_target = 12'd50;
    @(negedge clk);
    br_req = 1'b0;
    @(negedge clk);
    check("R8 no pulse from lone branch", longint'(insn_valid), 0);
    finish_insn(1'b0, 0, 1'b0);
    get_insn("R8 sequence kept, right of word 2", r_op(2), r_ad(2));
    check("R8 no read at ignored target", last_addr, 2);
    finish_insn(1'b0, 0, 1'b0);
  endtask

  task automatic t_branch_discard();
    int r0;
    get_insn("R2 left of word 3", l_op(3), l_ad(3));
    r0 = reads;
    finish_insn(1'b1, 10, 1'b0);   // buffer holds right of 3
    get_insn("R7 stale half dropped, left of 10", l_op(10), l_ad(10));
    check("R7 read at target", last_addr, 10);
    check("R7 one read for target", reads, r0 + 1);
    finish_insn(1'b0, 0, 1'b0);
    get_insn("R7 right of 10", r_op(10), r_ad(10));
    finish_insn(1'b0, 0, 1'b0);
  endtask

  task automatic t_branch_right();
    get_insn("R2 left of word 11", l_op(11), l_ad(11));
    finish_insn(1'b1, 700, 1'b1);
    get_insn("R7 right entry of 700", r_op(700), r_ad(700));
    check("R7 right entry read address", last_addr, 700);
    finish_insn(1'b0, 0, 1'b0);
    get_insn("R7 left of 701 after right entry", l_op(701), l_ad(701));
    check("R7 word after target read", last_addr, 701);
    finish_insn(1'b0, 0, 1'b0);
    get_insn("R3 right of 701", r_op(701), r_ad(701));
    finish_insn(1'b1, 999, 1'b0);
  endtask

  task automatic t_wrap();
    get_insn("R4 left of 999", l_op(999), l_ad(999));
    finish_insn(1'b0, 0, 1'b0);
    get_insn("R4 right of 999", r_op(999), r_ad(999));
    finish_insn(1'b0, 0, 1'b0);
    get_insn("R4 wrapped left of 0", l_op(0), l_ad(0));
    check("R4 wrap read address", last_addr, 0);
    finish_insn(1'b0, 0, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_seq();
    t_pulse();
    t_ignore_branch();
    t_branch_discard();
    t_branch_right();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule